// File: doc/BRIEF.md
# Manchester Line Transmitter with Preamble

This block turns a parallel data word into a Manchester-coded serial line. When a word is taken in, the block can first send a preamble. The preamble uses one of four fixed patterns and runs for a programmable number of bit periods. After the preamble comes a single start marker and then the data bits, least significant bit first. Each bit period has two half-bit phases, and the line makes its coded transition at the boundary between them.

The line is paced by `half_tick_i`, a one-cycle strobe at twice the bit rate that an external rate generator supplies. A word is handed over with a valid/ready handshake, and ready is high only while the transmitter is idle. The preamble length, the preamble pattern and the data polarity are captured together with the word. They stay fixed until the frame is over. Between frames the line rests low.

Top module: `man_tx`

## Requirements
- R1: While `rst_ni` is low and after reset is released, `line_o` is 0, `busy_o` is 0 and `ready_o` is 1.
- R2: `ready_o` is 1 exactly when the block is idle. A word is taken on a rising edge where `valid_i` and `ready_o` are both 1, and `busy_o` is 1 from the next cycle on. `valid_i` has no effect while busy.
- R3: `line_o` changes only on a clock edge where `half_tick_i` is 1.
- R4: With `pol_i` = 0, a data bit b is sent as level b in the first half and level ~b in the second half. A zero is therefore low-to-high and a one is high-to-low.
- R5: With `pol_i` = 1, the mapping is inverted. A data bit b is sent as ~b in the first half and b in the second half.
- R6: A frame is sent in this order: the preamble symbols, then a start marker, then the DW data bits LSB first, then one half period at idle level. The start marker is a logic zero coded with the data polarity. `busy_o` falls on the same edge that returns the line to idle.
- R7: A preamble length of 0 sends no preamble, so the start marker begins on the first half-tick.
- R8: A preamble length L from 1 to 15 sends exactly L preamble bit periods. The frame lasts 2*(L+1+DW)+1 half-ticks.
- R9: Preamble pattern codes are 0 = every symbol one, 1 = every symbol zero, 2 = zero,one,zero,... and 3 = one,zero,one,...
- R10: Preamble symbols are always coded with the polarity-0 mapping, whatever the value of `pol_i`.
- R11: The length, pattern, polarity and data are sampled on the accepting edge. Changes to them during a frame do not alter that frame.
- R12: Whenever `busy_o` is 0, `line_o` is at the idle level 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DW (8) | Word to send |
| valid_i | input | 1 | Word offered |
| ready_o | output | 1 | Idle, word can be taken |
| half_tick_i | input | 1 | Strobe at twice the bit rate |
| pre_len_i | input | LW (4) | Preamble length in bit periods, 0 = none |
| pre_pat_i | input | 2 | Preamble pattern code |
| pol_i | input | 1 | Data polarity select |
| line_o | output | 1 | Manchester line |
| busy_o | output | 1 | Frame in progress |

## Verification
`busy_o` and `ready_o` change on the accepting edge, so the bench checks them at the falling edge right after it. Each new half-symbol level appears on `line_o` one register stage after the edge that samples `half_tick_i`. The bench raises every tick for exactly one cycle and reads the line at the next falling edge. It then holds the tick low for two more cycles and checks that the line has not moved. For the half-symbol at index h, the bench works out the expected level itself from the requirements. `busy_o` is expected to stay high until the final idle half, which is the 2*(L+9)+1-th tick.

// File: rtl/man_tx_pkg.sv
`timescale 1ns/1ps
package man_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_START, ST_DATA, ST_STOP
  } tx_state_e;

  typedef enum logic [1:0] {
    PAT_ONES     = 2'd0,
    PAT_ZEROS    = 2'd1,
    PAT_ZERO_ONE = 2'd2,
    PAT_ONE_ZERO = 2'd3
  } pre_pat_e;

  localparam logic IDLE_LVL = 1'b0;
endpackage

// File: rtl/man_tx_ctrl.sv
`timescale 1ns/1ps
module man_tx_ctrl
  import man_tx_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  input  logic          half_tick_i,
  input  logic [LW-1:0] pre_len_i,
  input  logic [1:0]    pre_pat_i,
  input  logic          pol_i,
  output logic          ready_o,
  output logic          busy_o,
  output tx_state_e     state_o,
  output logic          cnt_lsb_o,
  output logic          second_o,
  output logic          emit_o,
  output logic          stop_o,
  output logic [1:0]    pat_o,
  output logic          pol_o,
  output logic          dbit_o
);
  localparam int DCW = (DW > 1) ? $clog2(DW) : 1;
  localparam int CW  = (LW > DCW) ? LW : DCW;

  tx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          half_q;
  logic [LW-1:0] len_q;
  logic [1:0]    pat_q;
  logic          pol_q;
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      len_q   <= '0;
      pat_q   <= '0;
      pol_q   <= 1'b0;
      sh_q    <= '0;
    end else if (state_q == ST_IDLE) begin
      if (valid_i) begin
        len_q   <= pre_len_i;
        pat_q   <= pre_pat_i;
        pol_q   <= pol_i;
        sh_q    <= data_i;
        cnt_q   <= '0;
        half_q  <= 1'b0;
        state_q <= (pre_len_i != '0) ? ST_PRE : ST_START;
      end
    end else if (half_tick_i) begin
      if (state_q == ST_STOP) begin
        state_q <= ST_IDLE;
      end else if (!half_q) begin
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
        unique case (state_q)
          ST_PRE: begin
            if (cnt_q == CW'(len_q - 1'b1)) begin
              cnt_q   <= '0;
              state_q <= ST_START;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_START: begin
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
          ST_DATA: begin
            sh_q <= sh_q >> 1;
            if (cnt_q == CW'(DW - 1)) begin
              cnt_q   <= '0;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign busy_o    = (state_q != ST_IDLE);
  assign state_o   = state_q;
  assign cnt_lsb_o = cnt_q[0];
  assign second_o  = half_q;
  assign emit_o    = half_tick_i && (state_q != ST_IDLE);
  assign stop_o    = (state_q == ST_STOP);
  assign pat_o     = pat_q;
  assign pol_o     = pol_q;
  assign dbit_o    = sh_q[0];
endmodule

// File: rtl/man_tx_sym.sv
`timescale 1ns/1ps
module man_tx_sym
  import man_tx_pkg::*;
(
  input  tx_state_e  state_i,
  input  logic       cnt_lsb_i,
  input  logic [1:0] pat_i,
  input  logic       pol_i,
  input  logic       dbit_i,
  output logic       bit_o,
  output logic       inv_o
);
  logic pre_bit;

  always_comb begin
    unique case (pre_pat_e'(pat_i))
      PAT_ONES:     pre_bit = 1'b1;
      PAT_ZEROS:    pre_bit = 1'b0;
      PAT_ZERO_ONE: pre_bit = cnt_lsb_i;
      default:      pre_bit = ~cnt_lsb_i;
    endcase
  end

  always_comb begin
    bit_o = 1'b0;
    inv_o = pol_i;
    unique case (state_i)
      ST_PRE: begin
        bit_o = pre_bit;
        inv_o = 1'b0;    // preamble ignores data polarity
      end
      ST_DATA: bit_o = dbit_i;
      default: bit_o = 1'b0;  // start marker codes as zero
    endcase
  end
endmodule

// File: rtl/man_tx_enc.sv
`timescale 1ns/1ps
module man_tx_enc
  import man_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic emit_i,
  input  logic stop_i,
  input  logic second_i,
  input  logic bit_i,
  input  logic inv_i,
  output logic line_o
);
  logic line_q;
  logic level;

  assign level = stop_i ? IDLE_LVL : ((bit_i ^ inv_i) ^ second_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     line_q <= IDLE_LVL;
    else if (emit_i) line_q <= level;
  end

  assign line_o = line_q;
endmodule

// File: rtl/man_tx.sv
`timescale 1ns/1ps
module man_tx
  import man_tx_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  output logic          ready_o,
  input  logic          half_tick_i,
  input  logic [LW-1:0] pre_len_i,
  input  logic [1:0]    pre_pat_i,
  input  logic          pol_i,
  output logic          line_o,
  output logic          busy_o
);
  tx_state_e  state;
  logic       cnt_lsb, second, emit, stop, pol_q, dbit, sym_bit, sym_inv;
  logic [1:0] pat_q;

  man_tx_ctrl #(.DW(DW), .LW(LW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .valid_i    (valid_i),
    .half_tick_i(half_tick_i),
    .pre_len_i  (pre_len_i),
    .pre_pat_i  (pre_pat_i),
    .pol_i      (pol_i),
    .ready_o    (ready_o),
    .busy_o     (busy_o),
    .state_o    (state),
    .cnt_lsb_o  (cnt_lsb),
    .second_o   (second),
    .emit_o     (emit),
    .stop_o     (stop),
    .pat_o      (pat_q),
    .pol_o      (pol_q),
    .dbit_o     (dbit)
  );

  man_tx_sym u_sym (
    .state_i  (state),
    .cnt_lsb_i(cnt_lsb),
    .pat_i    (pat_q),
    .pol_i    (pol_q),
    .dbit_i   (dbit),
    .bit_o    (sym_bit),
    .inv_o    (sym_inv)
  );

  man_tx_enc u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .emit_i  (emit),
    .stop_i  (stop),
    .second_i(second),
    .bit_i   (sym_bit),
    .inv_i   (sym_inv),
    .line_o  (line_o)
  );
endmodule

// File: rtl/man_tx_chk.sv
`timescale 1ns/1ps
module man_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic half_tick_i,
  input logic line_o,
  input logic busy_o
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> busy_o);  // R2

  AST_NO_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o);  // R2

  AST_LINE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_tick_i |=> $stable(line_o));  // R3

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !line_o);  // R12
endmodule

bind man_tx man_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .ready_o    (ready_o),
  .half_tick_i(half_tick_i),
  .line_o     (line_o),
  .busy_o     (busy_o)
);

// File: tb/man_tx_test.sv
`timescale 1ns/1ps
module man_tx_test;
  localparam int DW = 8;
  localparam int LW = 4;
  localparam int NV = 8;
  // {scramble, data, len, pat, pol}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 8'hA5, 4'd0,  2'd0, 1'b0},
    {1'b0, 8'h3C, 4'd1,  2'd0, 1'b0},
    {1'b0, 8'h5A, 4'd3,  2'd1, 1'b1},
    {1'b0, 8'h81, 4'd4,  2'd2, 1'b0},
    {1'b1, 8'h7E, 4'd5,  2'd3, 1'b1},
    {1'b0, 8'hFF, 4'd2,  2'd2, 1'b1},
    {1'b1, 8'h00, 4'd15, 2'd3, 1'b0},
    {1'b1, 8'hC3, 4'd6,  2'd1, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] data = '0;
  logic          valid = 1'b0;
  logic          tick = 1'b0;
  logic [LW-1:0] plen = '0;
  logic [1:0]    ppat = '0;
  logic          pol = 1'b0;
  logic          ready, line, busy;
  int            total = 0;
  int            bad = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  man_tx #(.DW(DW), .LW(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid),
    .ready_o(ready), .half_tick_i(tick), .pre_len_i(plen),
    .pre_pat_i(ppat), .pol_i(pol), .line_o(line), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_half(input int h, input logic [7:0] d,
                                    input int len, input logic [1:0] pat, input logic p);
    int   s = h / 2;
    logic sec = logic'(h % 2);
    logic b;
    logic inv;
    if (h >= 2 * (len + 1 + DW)) return 1'b0;
    if (s < len) begin
      inv = 1'b0;
      case (pat)
        2'd0:    b = 1'b1;
        2'd1:    b = 1'b0;
        2'd2:    b = logic'(s % 2);
        default: b = ~logic'(s % 2);
      endcase
    end else if (s == len) begin
      b = 1'b0; inv = p;
    end else begin
      b = d[s - len - 1]; inv = p;
    end
    return (b ^ inv) ^ sec;
  endfunction

  function automatic string tag_of(input int h, input int len, input logic p);
    int s = h / 2;
    if (h >= 2 * (len + 1 + DW)) return "R12";
    if (s < len) return "R9";
    if (s == len) return "R6";
    return p ? "R5" : "R4";
  endfunction

  // one half-tick, sample after update, then check line holds between ticks
  task automatic do_tick(output logic lv);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    lv = line;
    @(negedge clk);
    @(negedge clk);
    check(line == lv, "R3 line moved without tick", int'(line), int'(lv));
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [3:0] len,
                            input logic [1:0] pat, input logic p, input bit scr);
    int   n = 2 * (int'(len) + 1 + DW) + 1;
    logic lv;
    check(ready == 1'b1, "R2 ready before accept", int'(ready), 1);
    data = d; plen = len; ppat = pat; pol = p; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check(busy == 1'b1 && ready == 1'b0, "R2 busy after accept", int'(busy), 1);
    if (scr) begin  // R11: disturb sampled inputs during frame
      data = ~d; plen = ~len; ppat = ~pat; pol = ~p; valid = 1'b1;
    end
    for (int h = 0; h < n; h++) begin
      if (h == n - 1) valid = 1'b0;
      do_tick(lv);
      begin
        logic e = exp_half(h, d, int'(len), pat, p);
        check(lv == e, scr ? "R11" : tag_of(h, int'(len), p), int'(lv), int'(e));
      end
      check(busy == (h < n - 1), (len == 0) ? "R7 frame length" : "R8 frame length",
            int'(busy), int'(h < n - 1));
    end
    valid = 1'b0;
    check(busy == 1'b0 && line == 1'b0, "R6 end of frame", int'(busy), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic lv;
    @(negedge clk);
    check(line == 1'b0 && busy == 1'b0 && ready == 1'b1, "R1 in reset", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(line == 1'b0 && busy == 1'b0 && ready == 1'b1, "R1 after reset", int'(line), 0);

    // R12: ticks while idle leave line low
    do_tick(lv);
    check(lv == 1'b0 && busy == 1'b0, "R12 idle tick", int'(lv), 0);

    for (int i = 0; i < NV; i++)
      send_frame(VEC[i][14:7], VEC[i][6:3], VEC[i][2:1], VEC[i][0], VEC[i][15]);

    // R10: all-ones preamble with both polarities sends identical preamble halves
    send_frame(8'h96, 4'd2, 2'd0, 1'b1, 1'b0);
    send_frame(8'h96, 4'd2, 2'd0, 1'b0, 1'b0);

    // R1: reset mid-frame returns to idle
    data = 8'h55; plen = 4'd3; ppat = 2'd2; pol = 1'b0; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    do_tick(lv);
    do_tick(lv);
    rst_n = 1'b0;
    @(negedge clk);
    check(line == 1'b0 && busy == 1'b0 && ready == 1'b1, "R1 mid-frame reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    send_frame(8'h01, 4'd0, 2'd3, 1'b1, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule